// File: doc/BRIEF.md
# Multi-Mode PLL Programming Register

This block stores the divider settings of an integer-N frequency synthesizer and delivers them to the reference, main and swallow counters. A 20-bit working word can be filled in one of three ways. The first is a bit-serial port. The second is an 8-bit bus with one write strobe for each byte. The third mode bypasses the stored words and takes the counter values straight from pins. An 8-bit option byte sits next to the working word and can also be filled from the serial port or from the bus.

Frequency hopping uses double buffering. The working (primary) word can be rewritten while the counters run from a copy held in a secondary word. A rising load or hop strobe moves the primary word into the secondary word, so the new frequency takes effect on a single edge. A frame-select input chooses which of the two words drives the counters. All strobes and serial lines are asynchronous to the system clock. Each one passes through a synchronizer and an edge detector before it acts.

Top module: `pll_prog_reg`

## Requirements
- R1: An active-low reset clears the primary word, the secondary word and the option byte to zero.
- R2: When `dirMode`=1 the block is in pin mode. When `dirMode`=0 and `serSel`=1 it is in serial mode, and when both are 0 it is in bus mode. Strobes that belong to another mode leave every stored word unchanged.
- R3: In serial mode, while `loadN` is low and `optSel` is low, each rising `sclk` edge shifts `sdata` into bit 0 of the primary word, so the first bit sent ends at the MSB. The word layout is bit 19 = prescaler enable, bits 18:10 = M, bits 9:4 = R, bits 3:0 = A.
- R4: In serial mode, while `loadN` is low and `optSel` is high, each rising `sclk` edge shifts `sdata` into the option byte, MSB first. The primary word does not change.
- R5: In serial mode, a rising edge on `loadN` copies the primary word into the secondary word.
- R6: In serial or bus mode, a rising edge on `hopWr` copies the primary word into the secondary word.
- R7: In bus mode, a rising edge on `m1Wr` loads `dataBus[7]` into the prescaler enable and `dataBus[6:0]` into M[6:0].
- R8: In bus mode, a rising edge on `aWr` loads `dataBus[7:4]` into R[3:0] and `dataBus[3:0]` into A[3:0].
- R9: In bus mode, a rising edge on `m2Wr` loads `dataBus[3:2]` into R[5:4] and `dataBus[1:0]` into M[8:7]. No other field changes.
- R10: In bus mode, a rising edge on `optSel` loads `dataBus[7:0]` into the option byte.
- R11: Outside pin mode, `frameSel`=1 drives the counter outputs from the primary word and `frameSel`=0 drives them from the secondary word.
- R12: In pin mode the outputs are M = {00, `pinM`}, R = {00, `pinR`}, A = `pinA` and prescaler enable = `pinPreEn`, and no stored word changes.
- R13: `optBits` equals the option byte while `optEnN` is low and is all zeros while `optEnN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirMode | input | 1 | 1 selects pin mode |
| serSel | input | 1 | 1 selects serial mode, 0 selects bus mode (when `dirMode`=0) |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data |
| loadN | input | 1 | Serial load enable: low shifts, rising edge transfers |
| optSel | input | 1 | Serial target select, and the option-byte write strobe in bus mode |
| m1Wr | input | 1 | Bus strobe for prescaler enable and M[6:0] |
| aWr | input | 1 | Bus strobe for R[3:0] and A[3:0] |
| m2Wr | input | 1 | Bus strobe for R[5:4] and M[8:7] |
| hopWr | input | 1 | Hop strobe, primary to secondary |
| dataBus | input | 8 | Parallel data byte |
| frameSel | input | 1 | 1 selects primary, 0 selects secondary |
| optEnN | input | 1 | Active-low enable for option-byte outputs |
| pinM | input | 7 | Pin-mode M value |
| pinA | input | 4 | Pin-mode A value |
| pinR | input | 4 | Pin-mode R value |
| pinPreEn | input | 1 | Pin-mode prescaler enable |
| rDiv | output | 6 | Reference counter value |
| mDiv | output | 9 | Main counter value |
| aDiv | output | 4 | Swallow counter value |
| preEn | output | 1 | Prescaler enable |
| optBits | output | 8 | Gated option byte |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 20-bit word split 9/6/4/1, and an 8-bit option byte. With these values every strobe takes effect three clocks after its pin rises. Each bus strobe can therefore be checked on its own, and a full 20-bit serial frame and an 8-bit option frame both fit in a short run. The bench builds the secondary word with one mode and then compares it against a newer primary word loaded through another mode. It also tries strobes in the wrong mode and clears the block with a reset partway through the run.

// File: rtl/pllcfg_pkg.sv
`timescale 1ns/1ps
package pllcfg_pkg;
  typedef enum logic [1:0] {
    MODE_BUS = 2'd0,
    MODE_SER = 2'd1,
    MODE_PIN = 2'd2
  } mode_t;

  typedef struct packed {
    logic shiftPrim;
    logic shiftOpt;
    logic serBit;
    logic xferSec;
    logic ldM1;
    logic ldA;
    logic ldM2;
    logic ldOpt;
  } strobe_t;
endpackage

// File: rtl/pll_sync_bank.sv
`timescale 1ns/1ps
module pll_sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pll_prog_ctl.sv
`timescale 1ns/1ps
module pll_prog_ctl
  import pllcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    dirMode,
  input  logic    serSel,
  input  logic    sclk,
  input  logic    sdata,
  input  logic    loadN,
  input  logic    optSel,
  input  logic    m1Wr,
  input  logic    aWr,
  input  logic    m2Wr,
  input  logic    hopWr,
  output mode_t   mode,
  output strobe_t stb
);
  localparam int NUM_SIG = 8;
  localparam int I_HOP  = 0;
  localparam int I_M2   = 1;
  localparam int I_A    = 2;
  localparam int I_M1   = 3;
  localparam int I_OPT  = 4;
  localparam int I_LOAD = 5;
  localparam int I_SCLK = 6;
  localparam int I_SDAT = 7;

  logic [NUM_SIG-1:0] rawIn, syncQ, prevQ, rise;

  assign rawIn = {sdata, sclk, loadN, optSel, m1Wr, aWr, m2Wr, hopWr};

  pll_sync_bank #(.WIDTH(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawIn),
    .syncOut(syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  assign rise = syncQ & ~prevQ;

  always_comb begin
    if (dirMode)     mode = MODE_PIN;
    else if (serSel) mode = MODE_SER;
    else             mode = MODE_BUS;
  end

  logic serMode, busMode, shiftWin;
  assign serMode  = (mode == MODE_SER);
  assign busMode  = (mode == MODE_BUS);
  assign shiftWin = serMode & rise[I_SCLK] & ~syncQ[I_LOAD];

  always_comb begin
    stb           = '0;
    stb.serBit    = syncQ[I_SDAT];
    stb.shiftPrim = shiftWin & ~syncQ[I_OPT];
    stb.shiftOpt  = shiftWin &  syncQ[I_OPT];
    stb.xferSec   = (serMode & rise[I_LOAD]) | ((serMode | busMode) & rise[I_HOP]);
    stb.ldM1      = busMode & rise[I_M1];
    stb.ldA       = busMode & rise[I_A];
    stb.ldM2      = busMode & rise[I_M2];
    stb.ldOpt     = busMode & rise[I_OPT];
  end
endmodule

// File: rtl/pll_prog_dp.sv
`timescale 1ns/1ps
module pll_prog_dp
  import pllcfg_pkg::*;
#(
  parameter int A_W   = 4,
  parameter int R_W   = 6,
  parameter int M_W   = 9,
  parameter int OPT_W = 8,
  parameter int BUS_W = 8,
  parameter int PIN_W = 7,
  parameter int PINR_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  mode_t                mode,
  input  logic [BUS_W-1:0]     dataBus,
  input  logic                 frameSel,
  input  logic                 optEnN,
  input  logic [PIN_W-1:0]     pinM,
  input  logic [A_W-1:0]       pinA,
  input  logic [PINR_W-1:0]    pinR,
  input  logic                 pinPreEn,
  output logic [R_W-1:0]       rDiv,
  output logic [M_W-1:0]       mDiv,
  output logic [A_W-1:0]       aDiv,
  output logic                 preEn,
  output logic [OPT_W-1:0]     optBits,
  output logic [A_W+R_W+M_W:0] primWord,
  output logic [A_W+R_W+M_W:0] secWord,
  output logic [OPT_W-1:0]     optWord
);
  localparam int WORD_W = A_W + R_W + M_W + 1;
  localparam int A_LSB  = 0;
  localparam int R_LSB  = A_W;
  localparam int M_LSB  = A_W + R_W;
  localparam int PE_BIT = A_W + R_W + M_W;

  logic [WORD_W-1:0] primReg, secReg, selWord;
  logic [OPT_W-1:0]  optReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primReg <= '0;
    end else if (stb.shiftPrim) begin
      primReg <= {primReg[WORD_W-2:0], stb.serBit};
    end else begin
      if (stb.ldM1) begin
        primReg[PE_BIT]       <= dataBus[7];
        primReg[M_LSB +: 7]   <= dataBus[6:0];
      end
      if (stb.ldA) begin
        primReg[R_LSB +: 4]   <= dataBus[7:4];
        primReg[A_LSB +: 4]   <= dataBus[3:0];
      end
      if (stb.ldM2) begin
        primReg[R_LSB+4 +: 2] <= dataBus[3:2];
        primReg[M_LSB+7 +: 2] <= dataBus[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            secReg <= '0;
    else if (stb.xferSec) secReg <= primReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             optReg <= '0;
    else if (stb.shiftOpt) optReg <= {optReg[OPT_W-2:0], stb.serBit};
    else if (stb.ldOpt)    optReg <= dataBus[OPT_W-1:0];
  end

  assign selWord = frameSel ? primReg : secReg;

  always_comb begin
    if (mode == MODE_PIN) begin
      mDiv  = M_W'(pinM);
      rDiv  = R_W'(pinR);
      aDiv  = pinA;
      preEn = pinPreEn;
    end else begin
      mDiv  = selWord[M_LSB +: M_W];
      rDiv  = selWord[R_LSB +: R_W];
      aDiv  = selWord[A_LSB +: A_W];
      preEn = selWord[PE_BIT];
    end
  end

  assign optBits  = optEnN ? '0 : optReg;
  assign primWord = primReg;
  assign secWord  = secReg;
  assign optWord  = optReg;
endmodule

// File: rtl/pll_prog_reg.sv
`timescale 1ns/1ps
module pll_prog_reg
  import pllcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int A_W   = 4,
  parameter int R_W   = 6,
  parameter int M_W   = 9,
  parameter int OPT_W = 8,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirMode,
  input  logic             serSel,
  input  logic             sclk,
  input  logic             sdata,
  input  logic             loadN,
  input  logic             optSel,
  input  logic             m1Wr,
  input  logic             aWr,
  input  logic             m2Wr,
  input  logic             hopWr,
  input  logic [BUS_W-1:0] dataBus,
  input  logic             frameSel,
  input  logic             optEnN,
  input  logic [6:0]       pinM,
  input  logic [A_W-1:0]   pinA,
  input  logic [3:0]       pinR,
  input  logic             pinPreEn,
  output logic [R_W-1:0]   rDiv,
  output logic [M_W-1:0]   mDiv,
  output logic [A_W-1:0]   aDiv,
  output logic             preEn,
  output logic [OPT_W-1:0] optBits
);
  localparam int WORD_W = A_W + R_W + M_W + 1;

  mode_t             mode;
  strobe_t           stb;
  logic [WORD_W-1:0] primWord, secWord;
  logic [OPT_W-1:0]  optWord;

  pll_prog_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .dirMode(dirMode), .serSel(serSel),
    .sclk(sclk), .sdata(sdata), .loadN(loadN), .optSel(optSel),
    .m1Wr(m1Wr), .aWr(aWr), .m2Wr(m2Wr), .hopWr(hopWr),
    .mode(mode), .stb(stb)
  );

  pll_prog_dp #(
    .A_W(A_W), .R_W(R_W), .M_W(M_W), .OPT_W(OPT_W), .BUS_W(BUS_W),
    .PIN_W(7), .PINR_W(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode), .dataBus(dataBus),
    .frameSel(frameSel), .optEnN(optEnN), .pinM(pinM), .pinA(pinA),
    .pinR(pinR), .pinPreEn(pinPreEn), .rDiv(rDiv), .mDiv(mDiv),
    .aDiv(aDiv), .preEn(preEn), .optBits(optBits),
    .primWord(primWord), .secWord(secWord), .optWord(optWord)
  );
endmodule

// File: rtl/pll_prog_reg_chk.sv
`timescale 1ns/1ps
module pll_prog_reg_chk
  import pllcfg_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int OPT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dirMode,
  input logic              frameSel,
  input logic              optEnN,
  input logic [6:0]        pinM,
  input logic [3:0]        pinR,
  input logic [8:0]        mDiv,
  input logic [5:0]        rDiv,
  input logic [3:0]        aDiv,
  input logic              preEn,
  input logic [OPT_W-1:0]  optBits,
  input strobe_t           stb,
  input logic [WORD_W-1:0] primWord,
  input logic [WORD_W-1:0] secWord,
  input logic [OPT_W-1:0]  optWord
);
  assert_serial_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftPrim |=> primWord == {$past(primWord[WORD_W-2:0]), $past(stb.serBit)});

  assert_hop_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.xferSec |=> secWord == $past(primWord));

  assert_frame_prim_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!dirMode && frameSel) |-> {preEn, mDiv, rDiv, aDiv} == primWord);

  assert_frame_sec_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!dirMode && !frameSel) |-> {preEn, mDiv, rDiv, aDiv} == secWord);

  assert_pin_upper_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    dirMode |-> (mDiv == {2'b00, pinM}) && (rDiv == {2'b00, pinR}));

  assert_pin_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    dirMode |=> $stable(primWord) && $stable(secWord) && $stable(optWord));

  assert_opt_gate_R13: assert property (@(posedge clk) disable iff (!rstN)
    optEnN |-> optBits == '0);
endmodule

bind pll_prog_reg pll_prog_reg_chk #(.WORD_W(WORD_W), .OPT_W(OPT_W)) u_chk (
  .clk(clk), .rstN(rstN), .dirMode(dirMode), .frameSel(frameSel),
  .optEnN(optEnN), .pinM(pinM), .pinR(pinR), .mDiv(mDiv), .rDiv(rDiv),
  .aDiv(aDiv), .preEn(preEn), .optBits(optBits), .stb(stb),
  .primWord(primWord), .secWord(secWord), .optWord(optWord)
);

// File: tb/pll_prog_reg_tb.sv
`timescale 1ns/1ps
module pll_prog_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirMode = 1'b0, serSel = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic loadN = 1'b1, optSel = 1'b0, m1Wr = 1'b0, aWr = 1'b0, m2Wr = 1'b0, hopWr = 1'b0;
  logic [7:0] dataBus = '0;
  logic frameSel = 1'b1, optEnN = 1'b0, pinPreEn = 1'b0;
  logic [6:0] pinM = '0;
  logic [3:0] pinA = '0, pinR = '0;
  logic [5:0] rDiv;
  logic [8:0] mDiv;
  logic [3:0] aDiv;
  logic preEn;
  logic [7:0] optBits;

  always #2.5 clk = ~clk;

  pll_prog_reg u_dut (
    .clk(clk), .rstN(rstN), .dirMode(dirMode), .serSel(serSel), .sclk(sclk),
    .sdata(sdata), .loadN(loadN), .optSel(optSel), .m1Wr(m1Wr), .aWr(aWr),
    .m2Wr(m2Wr), .hopWr(hopWr), .dataBus(dataBus), .frameSel(frameSel),
    .optEnN(optEnN), .pinM(pinM), .pinA(pinA), .pinR(pinR), .pinPreEn(pinPreEn),
    .rDiv(rDiv), .mDiv(mDiv), .aDiv(aDiv), .preEn(preEn), .optBits(optBits)
  );

  typedef struct {
    string      tag;
    logic [8:0] m;
    logic [5:0] r;
    logic [3:0] a;
    logic       pe;
    logic [7:0] opt;
  } item_t;

  item_t expQ[$];
  int nCmp = 0, nBad = 0;
  bit done = 0;

  logic [19:0] mdlPrim = '0, mdlSec = '0;
  logic [7:0]  mdlOpt = '0;

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nCmp++;
      if (mDiv !== it.m || rDiv !== it.r || aDiv !== it.a || preEn !== it.pe || optBits !== it.opt) begin
        nBad++;
        $display("FAIL %s: got m=%h r=%h a=%h pe=%b opt=%h exp m=%h r=%h a=%h pe=%b opt=%h",
                 it.tag, mDiv, rDiv, aDiv, preEn, optBits, it.m, it.r, it.a, it.pe, it.opt);
      end
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit busMode();
    return !dirMode && !serSel;
  endfunction

  function automatic bit serMode();
    return !dirMode && serSel;
  endfunction

  task automatic expectOut(input string tag);
    item_t it;
    logic [19:0] w;
    it.tag = tag;
    if (dirMode) begin
      it.m = {2'b00, pinM}; it.r = {2'b00, pinR}; it.a = pinA; it.pe = pinPreEn;
    end else begin
      w = frameSel ? mdlPrim : mdlSec;
      it.pe = w[19]; it.m = w[18:10]; it.r = w[9:4]; it.a = w[3:0];
    end
    it.opt = optEnN ? 8'h00 : mdlOpt;
    @(posedge clk);
    expQ.push_back(it);
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic strobeM1(input logic [7:0] d);
    dataBus = d; waitC(2); m1Wr = 1'b1; waitC(4); m1Wr = 1'b0; waitC(4);
    if (busMode()) begin mdlPrim[19] = d[7]; mdlPrim[16:10] = d[6:0]; end
  endtask

  task automatic strobeA(input logic [7:0] d);
    dataBus = d; waitC(2); aWr = 1'b1; waitC(4); aWr = 1'b0; waitC(4);
    if (busMode()) begin mdlPrim[7:4] = d[7:4]; mdlPrim[3:0] = d[3:0]; end
  endtask

  task automatic strobeM2(input logic [7:0] d);
    dataBus = d; waitC(2); m2Wr = 1'b1; waitC(4); m2Wr = 1'b0; waitC(4);
    if (busMode()) begin mdlPrim[9:8] = d[3:2]; mdlPrim[18:17] = d[1:0]; end
  endtask

  task automatic strobeOpt(input logic [7:0] d);
    dataBus = d; waitC(2); optSel = 1'b1; waitC(4); optSel = 1'b0; waitC(4);
    if (busMode()) mdlOpt = d;
  endtask

  task automatic strobeHop();
    hopWr = 1'b1; waitC(4); hopWr = 1'b0; waitC(4);
    if (!dirMode) mdlSec = mdlPrim;
  endtask

  task automatic shiftSerial(input logic [19:0] w, input int n, input bit toOpt);
    loadN = 1'b0; optSel = toOpt; waitC(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i]; waitC(3); sclk = 1'b1; waitC(4); sclk = 1'b0; waitC(3);
      if (serMode()) begin
        if (toOpt) mdlOpt  = {mdlOpt[6:0], w[i]};
        else       mdlPrim = {mdlPrim[18:0], w[i]};
      end
    end
  endtask

  task automatic releaseLoad();
    loadN = 1'b1; waitC(5);
    if (serMode()) mdlSec = mdlPrim;
    optSel = 1'b0; waitC(4);
  endtask

  task automatic doReset();
    rstN = 1'b0; waitC(3);
    mdlPrim = '0; mdlSec = '0; mdlOpt = '0;
    rstN = 1'b1; waitC(3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    waitC(3);
    rstN = 1'b1;
    waitC(4);
    // R1: reset state, primary and secondary
    frameSel = 1'b1; expectOut("R1 reset primary");
    frameSel = 1'b0; expectOut("R1 reset secondary");

    // bus mode byte writes: R7, R8, R9
    frameSel = 1'b1;
    strobeM1(8'hA5); expectOut("R7 m1 strobe");
    strobeA(8'h3C);  expectOut("R8 a strobe");
    strobeM2(8'h0E); expectOut("R9 m2 strobe");
    frameSel = 1'b0; expectOut("R11 secondary still zero");
    strobeHop();     expectOut("R6 hop copies primary");
    strobeM2(8'h01); frameSel = 1'b1; expectOut("R9 m2 only upper bits");
    frameSel = 1'b0; expectOut("R11 secondary holds old word");

    // option byte, bus path and gating
    strobeOpt(8'h5A); expectOut("R10 bus option load");
    optEnN = 1'b1;    expectOut("R13 option gated off");
    optEnN = 1'b0;

    // serial mode: bus strobes ignored
    serSel = 1'b1; frameSel = 1'b1;
    strobeM1(8'hFF); strobeA(8'h77); strobeOpt(8'h11);
    expectOut("R2 bus strobes ignored in serial mode");
    shiftSerial(20'hB37E9, 20, 1'b0);
    expectOut("R3 serial primary MSB first");
    frameSel = 1'b0; expectOut("R5 secondary before load edge");
    releaseLoad();   expectOut("R5 load edge transfers");
    shiftSerial(20'h000C3, 8, 1'b1);
    frameSel = 1'b1; expectOut("R4 serial option, primary unchanged");
    releaseLoad();
    shiftSerial(20'h4A1D2, 20, 1'b0);
    frameSel = 1'b0; strobeHop();
    expectOut("R6 hop in serial mode");
    releaseLoad();

    // pin mode
    serSel = 1'b0; dirMode = 1'b1;
    pinM = 7'h7F; pinA = 4'h5; pinR = 4'hA; pinPreEn = 1'b0;
    expectOut("R12 pin mode outputs");
    pinM = 7'h12; pinA = 4'hF; pinR = 4'h3; pinPreEn = 1'b1;
    expectOut("R12 pin mode follows pins");
    strobeA(8'h99); strobeOpt(8'hEE); strobeHop();
    dirMode = 1'b0; frameSel = 1'b1; expectOut("R2 pin mode strobes ignored primary");
    frameSel = 1'b0; expectOut("R12 pin mode secondary unchanged");

    // reset mid-run
    doReset();
    frameSel = 1'b1; expectOut("R1 reset after activity primary");
    frameSel = 1'b0; expectOut("R1 reset after activity secondary");

    waitC(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule